// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block produces the period count of a pulse-width modulator. A 16-bit counter advances once per prescaled tick. It counts up, counts down, counts up and then down, or holds its value. The prescaler divides the input clock by a power of two multiplied by a second, even factor. The active period can be rewritten immediately, or staged in a shadow register that takes effect when the counter reaches zero. The counter can be forced to a programmed phase value by a sync pulse.

Software writes three registers through a plain write port: control, period and phase. Downstream compare and output logic uses the running count, the count direction and two one-clock event strobes, one for reaching zero and one for reaching the period. A debug suspend input can stop the counter after its next step, stop it at the next zero, or be ignored.

Top module: `pwm_timebase`

## Requirements
- R1: While `rst_n` is low and after it rises, `count` is 0, `dir_down` is 0, both event strobes are low, `act_period` is all ones, and the counter is in hold mode.
- R2: In up mode (control bits [1:0] = 0), each advance adds one to the count. From a value at or above the active period it goes to 0, so one cycle lasts period+1 ticks. `zero_evt` is high for one clock in the clock in which `count` becomes 0. `period_evt` is high for one clock in the clock in which `count` becomes equal to the period. `dir_down` is 0.
- R3: In down mode (mode 1), each advance subtracts one. From 0 it reloads the period value. `dir_down` is 1.
- R4: In up-down mode (mode 2), the counter climbs to the period, then descends to 0, then climbs again. The sequence for period P repeats every 2P ticks. `dir_down` becomes 1 on the step that leaves the period and becomes 0 on the step that leaves 0.
- R5: In hold mode (mode 3), `count` and `dir_down` do not change.
- R6: The counter advances once every D clocks, with D = 2^F × H. F is the power-of-two field, control bits [9:7]. H is 1 when the even-factor field, bits [6:4], is 0, and twice that field otherwise.
- R7: Every write to the control register restarts the prescaler. The first advance after the write comes D clocks after the write edge.
- R8: With control bit 3 clear, a period write (`cfg_sel` = 1) goes to a shadow register. The shadow value becomes the active period on the same edge at which the count steps to 0.
- R9: With control bit 3 set, a period write updates `act_period` on the write edge.
- R10: With control bit 2 set, a high `sync_in` loads the phase register (`cfg_sel` = 2) into `count` on the next edge. This load has priority over counting. Control bit 10 selects the direction afterwards: 1 up, 0 down. With bit 2 clear, `sync_in` has no effect.
- R11: With suspend mode 0 (control bits [12:11]), a high `suspend_in` lets exactly one more advance happen and then holds the count until `suspend_in` falls.
- R12: With suspend mode 1, a high `suspend_in` lets the count run until it is 0 and then holds it at 0.
- R13: With suspend mode 2 or 3, `suspend_in` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 period, 2 phase, 3 none |
| cfg_wdata | input | CNT_W | Write data |
| sync_in | input | 1 | Phase load request |
| suspend_in | input | 1 | Debug suspend request |
| count | output | CNT_W | Current count |
| act_period | output | CNT_W | Active period value |
| dir_down | output | 1 | 1 while the counter is descending |
| zero_evt | output | 1 | One-clock strobe when the count becomes 0 |
| period_evt | output | 1 | One-clock strobe when the count becomes the period |

## Verification
The checker verifies the per-step rules on every clock: the step rules for up and down modes, that hold mode freezes the count, the phase load that follows a sync, and that each event strobe agrees with the count. Prescaler timing, the restart on a control write, the moment the shadow period is copied, the up-down turning points and the three suspend behaviours all depend on where in a cycle something happens. Only the bench scenarios show these, because they track exact clock counts from a known start.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;
  localparam int DIVF_W = 3;
  localparam int MAX_P2 = (1 << DIVF_W) - 1;
  localparam int HS_W   = DIVF_W + 1;
  localparam int PRE_W  = MAX_P2 + HS_W;

  typedef enum logic [1:0] {
    CM_UP     = 2'd0,
    CM_DOWN   = 2'd1,
    CM_UPDOWN = 2'd2,
    CM_HOLD   = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    SUS_STEP  = 2'd0,
    SUS_CYCLE = 2'd1,
    SUS_FREE  = 2'd2,
    SUS_FREE2 = 2'd3
  } sus_mode_e;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_PHASE  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    sus_mode_e         sus;
    logic              ph_up;
    logic [DIVF_W-1:0] pow2_div;
    logic [DIVF_W-1:0] hs_div;
    logic              prd_imm;
    logic              ph_en;
    cnt_mode_e         mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pwm_tb_prescaler.sv
module pwm_tb_prescaler
  import pwm_tb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [DIVF_W-1:0] pow2_div,
  input  logic [DIVF_W-1:0] hs_div,
  output logic              tick
);
  logic [HS_W-1:0]  hs_fac;
  logic [PRE_W-1:0] div_m1;
  logic [PRE_W-1:0] pre_q;

  // even factor: 1 for a zero field, else twice the field
  always_comb begin
    hs_fac = (hs_div == '0) ? HS_W'(1) : {hs_div, 1'b0};
    div_m1 = (PRE_W'(hs_fac) << pow2_div) - PRE_W'(1);
  end

  assign tick = (pre_q == div_m1);

  always_ff @(posedge clk) begin
    if (!rst_n)           pre_q <= '0;
    else if (clr || tick) pre_q <= '0;
    else                  pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/pwm_tb_period.sv
module pwm_tb_period #(
  parameter int              CNT_W   = 16,
  parameter logic [CNT_W-1:0] RST_PRD = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             imm,
  input  logic [CNT_W-1:0] wdata,
  input  logic             at_zero,
  output logic [CNT_W-1:0] period
);
  logic [CNT_W-1:0] shadow_q;
  logic [CNT_W-1:0] active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= RST_PRD;
      active_q <= RST_PRD;
    end else begin
      if (wr) shadow_q <= wdata;
      if (wr && imm)        active_q <= wdata;
      else if (at_zero)     active_q <= shadow_q;
    end
  end

  assign period = active_q;
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  cnt_mode_e        mode,
  input  sus_mode_e        sus,
  input  logic             ph_en,
  input  logic             ph_up,
  input  logic             suspend,
  input  logic             sync_in,
  input  logic [CNT_W-1:0] phase_val,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             dir_down,
  output logic             zero_evt,
  output logic             period_evt,
  output logic             at_zero
);
  logic [CNT_W-1:0] cnt_q, nxt;
  logic             dir_q, nxt_dir;
  logic             stop_q, halt, advance, load;
  logic             zev_q, pev_q;

  always_comb begin
    nxt     = cnt_q;
    nxt_dir = dir_q;
    unique case (mode)
      CM_UP: begin
        nxt_dir = 1'b0;
        nxt     = (cnt_q >= period) ? '0 : cnt_q + 1'b1;
      end
      CM_DOWN: begin
        nxt_dir = 1'b1;
        nxt     = (cnt_q == '0) ? period : cnt_q - 1'b1;
      end
      CM_UPDOWN: begin
        if (!dir_q) begin
          if (cnt_q >= period) begin
            nxt_dir = 1'b1;
            nxt     = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
          end else begin
            nxt = cnt_q + 1'b1;
          end
        end else begin
          if (cnt_q == '0) begin
            nxt_dir = 1'b0;
            nxt     = (period == '0) ? '0 : CNT_W'(1);
          end else begin
            nxt = cnt_q - 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  // suspend gating
  always_comb begin
    unique case (sus)
      SUS_STEP:  halt = stop_q;
      SUS_CYCLE: halt = suspend && (cnt_q == '0);
      default:   halt = 1'b0;
    endcase
  end

  assign load    = ph_en && sync_in;
  assign advance = tick && !halt && (mode != CM_HOLD) && !load;
  assign at_zero = advance && (nxt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      stop_q <= 1'b0;
      zev_q  <= 1'b0;
      pev_q  <= 1'b0;
    end else begin
      if (!suspend)                     stop_q <= 1'b0;
      else if (tick && sus == SUS_STEP) stop_q <= 1'b1;
      zev_q <= at_zero;
      pev_q <= advance && (nxt == period);
      if (load) begin
        cnt_q <= phase_val;
        dir_q <= !ph_up;
      end else if (advance) begin
        cnt_q <= nxt;
        dir_q <= nxt_dir;
      end
    end
  end

  assign count      = cnt_q;
  assign dir_down   = dir_q;
  assign zero_evt   = zev_q;
  assign period_evt = pev_q;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int               CNT_W   = 16,
  parameter logic [CNT_W-1:0] RST_PRD = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             sync_in,
  input  logic             suspend_in,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] act_period,
  output logic             dir_down,
  output logic             zero_evt,
  output logic             period_evt
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] phase_q;
  logic             wr_ctrl, wr_prd, wr_phase;
  logic             tick, at_zero;
  cnt_mode_e        mode_w;
  logic             ph_en_w;

  assign wr_ctrl  = cfg_we && (cfg_sel == SEL_CTRL);
  assign wr_prd   = cfg_we && (cfg_sel == SEL_PERIOD);
  assign wr_phase = cfg_we && (cfg_sel == SEL_PHASE);
  assign mode_w   = ctrl_q.mode;
  assign ph_en_w  = ctrl_q.ph_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      ctrl_q.mode <= CM_HOLD;
      ctrl_q.sus  <= SUS_FREE;
      phase_q     <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q  <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
      if (wr_phase) phase_q <= cfg_wdata;
    end
  end

  pwm_tb_prescaler u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (wr_ctrl),
    .pow2_div (ctrl_q.pow2_div),
    .hs_div   (ctrl_q.hs_div),
    .tick     (tick)
  );

  pwm_tb_period #(.CNT_W(CNT_W), .RST_PRD(RST_PRD)) u_prd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr_prd),
    .imm     (ctrl_q.prd_imm),
    .wdata   (cfg_wdata),
    .at_zero (at_zero),
    .period  (act_period)
  );

  pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .mode       (mode_w),
    .sus        (ctrl_q.sus),
    .ph_en      (ph_en_w),
    .ph_up      (ctrl_q.ph_up),
    .suspend    (suspend_in),
    .sync_in    (sync_in),
    .phase_val  (phase_q),
    .period     (act_period),
    .count      (count),
    .dir_down   (dir_down),
    .zero_evt   (zero_evt),
    .period_evt (period_evt),
    .at_zero    (at_zero)
  );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             sync_in,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] act_period,
  input logic             dir_down,
  input logic             zero_evt,
  input logic             period_evt,
  input cnt_mode_e        mode,
  input logic             ph_en,
  input logic [CNT_W-1:0] phase_val
);
  // R2
  zero_evt_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |-> (count == '0));

  // R2
  period_evt_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_evt |-> (count == $past(act_period)));

  // R2
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_UP && !sync_in && !cfg_we) |=>
      (!dir_down && (count == $past(count) + 1'b1 || count == '0 || count == $past(count))));

  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_DOWN && !sync_in && !cfg_we) |=>
      (dir_down && (count == $past(count) - 1'b1 || count == $past(act_period)
                    || count == $past(count))));

  // R5
  hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_HOLD && !sync_in && !cfg_we) |=> ($stable(count) && $stable(dir_down)));

  // R10
  phase_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_en && sync_in && !cfg_we) |=> (count == $past(phase_val)));
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .sync_in    (sync_in),
  .count      (count),
  .act_period (act_period),
  .dir_down   (dir_down),
  .zero_evt   (zero_evt),
  .period_evt (period_evt),
  .mode       (mode_w),
  .ph_en      (ph_en_w),
  .phase_val  (phase_q)
);

// File: tb/sim_pwm_timebase.sv
module sim_pwm_timebase;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_sel = 2'd0;
  logic [W-1:0] cfg_wdata = '0;
  logic         sync_in = 1'b0;
  logic         suspend_in = 1'b0;
  logic [W-1:0] count, act_period;
  logic         dir_down, zero_evt, period_evt;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  pwm_timebase #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .sync_in(sync_in), .suspend_in(suspend_in),
    .count(count), .act_period(act_period), .dir_down(dir_down),
    .zero_evt(zero_evt), .period_evt(period_evt)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // control word: [12:11] suspend, [10] phase up, [9:7] pow2, [6:4] even factor,
  // [3] immediate period, [2] phase enable, [1:0] mode
  function automatic logic [15:0] mk(input logic [1:0] m, input logic ph, input logic imm,
                                     input logic [2:0] hs, input logic [2:0] p2,
                                     input logic up, input logic [1:0] sus);
    return {3'b000, sus, up, p2, hs, imm, ph, m};
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; sync_in = 1'b0; suspend_in = 1'b0; cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_period_imm(input logic [1:0] m, input logic [15:0] p);
    wr(2'd0, mk(2'd3, 1'b0, 1'b1, 3'd0, 3'd0, 1'b0, 2'd2));
    wr(2'd1, p);
  endtask

  task automatic t_reset;
    do_reset();
    chk("R1", "count", count, 0);
    chk("R1", "dir_down", dir_down, 0);
    chk("R1", "zero_evt", zero_evt, 0);
    chk("R1", "period_evt", period_evt, 0);
    chk("R1", "act_period", act_period, 16'hFFFF);
    repeat (5) @(negedge clk);
    chk("R1", "held count", count, 0);
  endtask

  task automatic t_up;
    do_reset();
    set_period_imm(2'd0, 16'd4);
    wr(2'd0, mk(2'd0, 1'b0, 1'b1, 3'd0, 3'd0, 1'b0, 2'd2));
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      chk("R2", "up count", count, i % 5);
      chk("R2", "zero_evt", zero_evt, (i % 5) == 0);
      chk("R2", "period_evt", period_evt, (i % 5) == 4);
      chk("R2", "dir", dir_down, 0);
    end
  endtask

  task automatic t_down;
    do_reset();
    set_period_imm(2'd1, 16'd3);
    wr(2'd0, mk(2'd1, 1'b0, 1'b1, 3'd0, 3'd0, 1'b0, 2'd2));
    for (int i = 1; i <= 9; i++) begin
      @(negedge clk);
      chk("R3", "down count", count, (4 - (i % 4)) % 4);
      chk("R3", "dir", dir_down, 1);
    end
  endtask

  task automatic t_updown;
    logic [15:0] e;
    do_reset();
    set_period_imm(2'd2, 16'd3);
    wr(2'd0, mk(2'd2, 1'b0, 1'b1, 3'd0, 3'd0, 1'b0, 2'd2));
    for (int i = 1; i <= 13; i++) begin
      @(negedge clk);
      e = (i % 6 <= 3) ? 16'(i % 6) : 16'(6 - i % 6);
      chk("R4", "updown count", count, e);
      chk("R4", "dir", dir_down, (i % 6 == 0) || (i % 6 >= 4));
    end
  endtask

  task automatic t_hold;
    logic [15:0] c;
    do_reset();
    wr(2'd0, mk(2'd0, 1'b0, 1'b1, 3'd0, 3'd0, 1'b0, 2'd2));
    repeat (4) @(negedge clk);
    wr(2'd0, mk(2'd3, 1'b0, 1'b1, 3'd0, 3'd0, 1'b0, 2'd2));
    c = count;
    chk("R5", "count before hold", c, 5);
    repeat (6) @(negedge clk);
    chk("R5", "held count", count, c);
  endtask

  task automatic t_prescale;
    do_reset();
    wr(2'd0, mk(2'd0, 1'b0, 1'b1, 3'd3, 3'd1, 1'b0, 2'd2)); // 6 x 2 = 12
    repeat (11) @(negedge clk);
    chk("R6", "div12 before", count, 0);
    @(negedge clk);
    chk("R6", "div12 first", count, 1);
    repeat (12) @(negedge clk);
    chk("R6", "div12 second", count, 2);
    do_reset();
    wr(2'd0, mk(2'd0, 1'b0, 1'b1, 3'd0, 3'd2, 1'b0, 2'd2)); // 1 x 4 = 4
    repeat (3) @(negedge clk);
    chk("R6", "div4 before", count, 0);
    @(negedge clk);
    chk("R6", "div4 first", count, 1);
    repeat (4) @(negedge clk);
    chk("R6", "div4 second", count, 2);
  endtask

  task automatic t_restart;
    do_reset();
    wr(2'd0, mk(2'd0, 1'b0, 1'b1, 3'd3, 3'd1, 1'b0, 2'd2));
    repeat (30) @(negedge clk);
    chk("R7", "count at 30", count, 2);
    wr(2'd0, mk(2'd0, 1'b0, 1'b1, 3'd3, 3'd1, 1'b0, 2'd2));
    repeat (11) @(negedge clk);
    chk("R7", "no early tick", count, 2);
    @(negedge clk);
    chk("R7", "tick after restart", count, 3);
  endtask

  task automatic t_shadow;
    do_reset();
    set_period_imm(2'd3, 16'd5);
    wr(2'd0, mk(2'd3, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 2'd2));
    wr(2'd1, 16'd2);
    chk("R8", "shadow not active", act_period, 5);
    wr(2'd0, mk(2'd0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 2'd2));
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      chk("R8", "old period kept", act_period, 5);
      chk("R8", "count", count, i);
    end
    @(negedge clk);
    chk("R8", "wrap count", count, 0);
    chk("R8", "loaded at zero", act_period, 2);
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      chk("R8", "new cycle count", count, i % 3);
    end
  endtask

  task automatic t_imm;
    do_reset();
    set_period_imm(2'd3, 16'd5);
    wr(2'd0, mk(2'd0, 1'b0, 1'b1, 3'd0, 3'd0, 1'b0, 2'd2));
    repeat (2) @(negedge clk);
    wr(2'd1, 16'd7);
    chk("R9", "active now", act_period, 7);
    chk("R9", "count", count, 3);
    repeat (4) @(negedge clk);
    chk("R9", "past old period", count, 7);
    chk("R9", "period_evt", period_evt, 1);
    @(negedge clk);
    chk("R9", "wrap", count, 0);
  endtask

  task automatic t_phase;
    logic [15:0] c;
    do_reset();
    set_period_imm(2'd2, 16'd9);
    wr(2'd2, 16'd6);
    wr(2'd0, mk(2'd2, 1'b1, 1'b1, 3'd0, 3'd0, 1'b0, 2'd2));
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    chk("R10", "load down", count, 6);
    chk("R10", "dir down", dir_down, 1);
    @(negedge clk);
    chk("R10", "after load down", count, 5);
    wr(2'd0, mk(2'd2, 1'b1, 1'b1, 3'd0, 3'd0, 1'b1, 2'd2));
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    chk("R10", "load up", count, 6);
    chk("R10", "dir up", dir_down, 0);
    @(negedge clk);
    chk("R10", "after load up", count, 7);
    wr(2'd0, mk(2'd0, 1'b0, 1'b1, 3'd0, 3'd0, 1'b0, 2'd2));
    c = count;
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    chk("R10", "sync ignored", count, (c >= 9) ? 0 : c + 1);
  endtask

  task automatic t_sus_step;
    do_reset();
    wr(2'd0, mk(2'd0, 1'b0, 1'b1, 3'd0, 3'd0, 1'b0, 2'd0));
    repeat (3) @(negedge clk);
    chk("R11", "running", count, 3);
    suspend_in = 1'b1;
    @(negedge clk);
    chk("R11", "one more step", count, 4);
    repeat (6) @(negedge clk);
    chk("R11", "stopped", count, 4);
    suspend_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11", "resumed", count, 6);
  endtask

  task automatic t_sus_cycle;
    do_reset();
    set_period_imm(2'd3, 16'd4);
    wr(2'd0, mk(2'd0, 1'b0, 1'b1, 3'd0, 3'd0, 1'b0, 2'd1));
    repeat (2) @(negedge clk);
    suspend_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12", "still running", count, 4);
    @(negedge clk);
    chk("R12", "reached zero", count, 0);
    repeat (5) @(negedge clk);
    chk("R12", "held at zero", count, 0);
    suspend_in = 1'b0;
    @(negedge clk);
    chk("R12", "resumed", count, 1);
  endtask

  task automatic t_sus_free;
    do_reset();
    suspend_in = 1'b1;
    wr(2'd0, mk(2'd0, 1'b0, 1'b1, 3'd0, 3'd0, 1'b0, 2'd2));
    repeat (5) @(negedge clk);
    chk("R13", "free run mode 2", count, 5);
    wr(2'd0, mk(2'd0, 1'b0, 1'b1, 3'd0, 3'd0, 1'b0, 2'd3));
    repeat (3) @(negedge clk);
    chk("R13", "free run mode 3", count, 9);
    suspend_in = 1'b0;
  endtask

  task automatic finish_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      finish_up();
    end
  end

  initial begin
    t_reset();
    t_up();
    t_down();
    t_updown();
    t_hold();
    t_prescale();
    t_restart();
    t_shadow();
    t_imm();
    t_phase();
    t_sus_step();
    t_sus_cycle();
    t_sus_free();
    done = 1;
    finish_up();
  end
endmodule